// File: doc/BRIEF.md
# Conversion Result Address Generator

This block computes the RAM word offset at which a DMA engine stores each result from an analog-to-digital converter. For every result strobe it returns an offset and a one-cycle valid pulse. A single mode input chooses between two addressing schemes.

In ordered mode, results are placed at consecutive offsets in a single buffer. The offset wraps back to zero after a programmable last location.

In scatter mode, the buffer is divided into equal regions, one for each analog input. The region size is a power of two chosen by a 3-bit code. A result is written into the region owned by its input index, at a slot given by a shared pointer. That pointer moves forward once after a programmable number of sequence-complete pulses, and it wraps inside the region.

Dropping the enable input clears all of the block's state. The configuration inputs (mode, region code, sequence divider, last location) are held steady while the block is enabled.

Top module: `cvt_dma_addr`

## Requirements
- R1: While rst_ni is low, addr_o and addr_vld_o are 0.
- R2: A result strobe seen while enabled produces addr_vld_o high for exactly the next cycle, with addr_o valid in that same cycle. No other cycle has addr_vld_o high.
- R3: In ordered mode (ordered_mode_i = 1), the offsets run 0, 1, 2, ..., moving up by one per result. Sequence-complete pulses do not affect them.
- R4: In ordered mode, the result after the one placed at offset lin_last_i is placed at offset 0.
- R5: In scatter mode (ordered_mode_i = 0), the offset is input_idx_i × 2^k + p, where k = region_log2_i and p is the shared slot pointer.
- R6: A region code k (0 to 7) gives each input 2^k words. The slot pointer wraps modulo 2^k, so with k = 0 it is always 0.
- R7: In scatter mode, the slot pointer moves forward by one on every (d+1)-th sequence-complete pulse, where d = seq_div_i (0 to 15, giving 1 to 16 sequences).
- R8: When a result strobe and a sequence-complete pulse arrive in the same cycle, the result uses the slot pointer as it was before the step.
- R9: While enable_i is low, result strobes are ignored and addr_o is 0. All pointers and the sequence count restart from zero when enable_i is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable; low clears all state |
| ordered_mode_i | input | 1 | 1 = ordered mode, 0 = scatter mode |
| region_log2_i | input | 3 | Region size code k; each region is 2^k words |
| seq_div_i | input | 4 | Sequences per slot step, minus one |
| lin_last_i | input | 12 | Last offset used in ordered mode |
| result_vld_i | input | 1 | Result strobe |
| input_idx_i | input | 5 | Analog input index of the current result |
| seq_done_i | input | 1 | Sequence-complete strobe |
| addr_o | output | 12 | Word offset for the DMA write |
| addr_vld_o | output | 1 | One-cycle pulse marking addr_o valid |

## Verification
Random sessions choose the mode, region code, divider and last location, then drive random mixes of result strobes, input indices and sequence-complete pulses.

Random indices at several region codes show whether the index is scaled by the right power of two. Random spacing of sequence-complete pulses shows whether the pointer steps on the correct count rather than on every pulse.

Directed cases cover the extremes: k = 0 and k = 7, a divider of 16, a last location of 0, and coincident strobes. These separate the wrap and ordering corners from the common path. Enable toggles in the middle of a run show whether leftover state survives a restart.

// File: rtl/cvt_dma_pkg.sv
package cvt_dma_pkg;
  localparam int unsigned NUM_INPUTS = 32;
  localparam int unsigned IDX_W      = $clog2(NUM_INPUTS);
  localparam int unsigned LOG2_W     = 3;
  localparam int unsigned MAX_LOG2   = (1 << LOG2_W) - 1;
  localparam int unsigned ADDR_W     = IDX_W + MAX_LOG2;
  localparam int unsigned DIV_W      = 4;

  typedef enum logic {
    MODE_SCATTER = 1'b0,
    MODE_ORDERED = 1'b1
  } addr_mode_e;

  function automatic logic [MAX_LOG2-1:0] region_mask(input logic [LOG2_W-1:0] k);
    logic [MAX_LOG2:0] full;
    full = ({{MAX_LOG2{1'b0}}, 1'b1} << k) - 1'b1;
    return full[MAX_LOG2-1:0];
  endfunction
endpackage

// File: rtl/cvt_seq_pacer.sv
module cvt_seq_pacer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             seq_done_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             step_o
);
  logic [CNT_W-1:0] cnt_q;

  assign step_o = en_i & seq_done_i & (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (step_o)            cnt_q <= '0;
    else if (en_i & seq_done_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cvt_region_ptr.sv
module cvt_region_ptr
  import cvt_dma_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                step_i,
  input  logic [LOG2_W-1:0]   log2_i,
  output logic [MAX_LOG2-1:0] ptr_o
);
  logic [MAX_LOG2-1:0] mask;
  assign mask = region_mask(log2_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (clr_i)   ptr_o <= '0;
    else if (step_i)  ptr_o <= (ptr_o + 1'b1) & mask;
  end
endmodule

// File: rtl/cvt_linear_ptr.sv
module cvt_linear_ptr #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (clr_i) ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == last_i) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/cvt_dma_addr.sv
module cvt_dma_addr
  import cvt_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              ordered_mode_i,
  input  logic [LOG2_W-1:0] region_log2_i,
  input  logic [DIV_W-1:0]  seq_div_i,
  input  logic [ADDR_W-1:0] lin_last_i,
  input  logic              result_vld_i,
  input  logic [IDX_W-1:0]  input_idx_i,
  input  logic              seq_done_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_vld_o
);
  addr_mode_e mode;
  logic clr, accept, sg_run, step;
  logic [MAX_LOG2-1:0] region_ptr;
  logic [ADDR_W-1:0]   lin_ptr, sg_addr, addr_d;

  assign mode   = addr_mode_e'(ordered_mode_i);
  assign clr    = ~enable_i;
  assign accept = enable_i & result_vld_i;
  assign sg_run = enable_i & (mode == MODE_SCATTER);

  cvt_seq_pacer #(.CNT_W(DIV_W)) u_pacer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .en_i       (sg_run),
    .seq_done_i (seq_done_i),
    .div_i      (seq_div_i),
    .step_o     (step)
  );

  cvt_region_ptr u_region (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (step),
    .log2_i (region_log2_i),
    .ptr_o  (region_ptr)
  );

  cvt_linear_ptr #(.W(ADDR_W)) u_linear (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (accept & (mode == MODE_ORDERED)),
    .last_i (lin_last_i),
    .ptr_o  (lin_ptr)
  );

  // region base from index, slot from shared pointer
  assign sg_addr = (ADDR_W'(input_idx_i) << region_log2_i)
                 | ADDR_W'(region_ptr & region_mask(region_log2_i));
  assign addr_d  = (mode == MODE_ORDERED) ? lin_ptr : sg_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      addr_vld_o <= 1'b0;
    end else if (clr) begin
      addr_o     <= '0;
      addr_vld_o <= 1'b0;
    end else begin
      addr_vld_o <= accept;
      if (accept) addr_o <= addr_d;
    end
  end
endmodule

// File: rtl/cvt_dma_addr_chk.sv
module cvt_dma_addr_chk
  import cvt_dma_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                enable_i,
  input logic                ordered_mode_i,
  input logic [LOG2_W-1:0]   region_log2_i,
  input logic [ADDR_W-1:0]   lin_last_i,
  input logic                result_vld_i,
  input logic [IDX_W-1:0]    input_idx_i,
  input logic [ADDR_W-1:0]   addr_o,
  input logic                addr_vld_o,
  input logic [MAX_LOG2-1:0] region_ptr
);
  AST_VLD_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && result_vld_i) |=> addr_vld_o); // R2

  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enable_i && result_vld_i) |=> !addr_vld_o); // R2

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!addr_vld_o && addr_o == '0)); // R9

  AST_REGION_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_o && !$past(ordered_mode_i))
      |-> ((addr_o >> $past(region_log2_i)) == ADDR_W'($past(input_idx_i)))); // R5

  AST_LIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_o && $past(ordered_mode_i)) |-> (addr_o <= $past(lin_last_i))); // R4

  AST_SLOT_IN_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ADDR_W'(region_ptr) >> region_log2_i) == '0); // R6
endmodule

bind cvt_dma_addr cvt_dma_addr_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .enable_i       (enable_i),
  .ordered_mode_i (ordered_mode_i),
  .region_log2_i  (region_log2_i),
  .lin_last_i     (lin_last_i),
  .result_vld_i   (result_vld_i),
  .input_idx_i    (input_idx_i),
  .addr_o         (addr_o),
  .addr_vld_o     (addr_vld_o),
  .region_ptr     (region_ptr)
);

// File: tb/cvt_dma_addr_test.sv
module cvt_dma_addr_test;
  import cvt_dma_pkg::*;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              enable_i = 1'b0;
  logic              ordered_mode_i = 1'b0;
  logic [LOG2_W-1:0] region_log2_i = '0;
  logic [DIV_W-1:0]  seq_div_i = '0;
  logic [ADDR_W-1:0] lin_last_i = '0;
  logic              result_vld_i = 1'b0;
  logic [IDX_W-1:0]  input_idx_i = '0;
  logic              seq_done_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;
  logic              addr_vld_o;

  int checks = 0, fails = 0, cycles = 0;
  bit done_run = 0;

  int m_lin = 0, m_sg = 0, m_cnt = 0, m_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvt_dma_addr uut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .ordered_mode_i(ordered_mode_i),
    .region_log2_i(region_log2_i), .seq_div_i(seq_div_i), .lin_last_i(lin_last_i),
    .result_vld_i(result_vld_i), .input_idx_i(input_idx_i), .seq_done_i(seq_done_i),
    .addr_o(addr_o), .addr_vld_o(addr_vld_o)
  );

  function automatic int sg_offset(int idx, int k, int p);
    return idx * (1 << k) + p;
  endfunction

  task automatic check(string tag, int act_v, int exp_v, int act_a, int exp_a);
    checks++;
    if (act_v != exp_v || act_a != exp_a) begin
      fails++;
      $display("FAIL %s: vld=%0d addr=%0d, expected vld=%0d addr=%0d",
               tag, act_v, act_a, exp_v, exp_a);
    end
  endtask

  // drive one cycle at negedge, predict, check at next negedge
  task automatic cyc(bit res, int idx, bit done, string tag);
    int exp_v;
    result_vld_i = res;
    input_idx_i  = IDX_W'(idx);
    seq_done_i   = done;
    exp_v = 0;
    if (!enable_i) begin
      m_lin = 0; m_sg = 0; m_cnt = 0; m_addr = 0;
    end else begin
      if (res) begin
        exp_v  = 1;
        m_addr = ordered_mode_i ? m_lin : sg_offset(idx, int'(region_log2_i), m_sg);
      end
      if (ordered_mode_i && res) m_lin = (m_lin == int'(lin_last_i)) ? 0 : m_lin + 1;
      if (!ordered_mode_i && done) begin
        if (m_cnt == int'(seq_div_i)) begin
          m_cnt = 0;
          m_sg  = (m_sg + 1) % (1 << region_log2_i);
        end else m_cnt++;
      end
    end
    @(negedge clk);
    check(tag, int'(addr_vld_o), exp_v, int'(addr_o), m_addr);
  endtask

  task automatic session(bit ord, int k, int div, int last);
    enable_i = 1'b0;
    cyc(1, 3, 1, "R9");
    ordered_mode_i = ord;
    region_log2_i  = LOG2_W'(k);
    seq_div_i      = DIV_W'(div);
    lin_last_i     = ADDR_W'(last);
    enable_i       = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check("R1", int'(addr_vld_o), 0, int'(addr_o), 0);
    repeat (3) @(negedge clk);
    check("R1", int'(addr_vld_o), 0, int'(addr_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R3 R4: ordered run with wrap at 4, seq-done noise ignored
    session(1, 0, 0, 4);
    for (int i = 0; i < 12; i++) cyc(1, i, i[0], (i % 5 == 0) ? "R4" : "R3");
    // R4: last location 0 keeps every offset at 0
    session(1, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(1, i, 0, "R4");

    // R8: coincident strobe uses pre-step pointer
    session(0, 2, 0, 0);
    cyc(1, 5, 1, "R8");
    cyc(1, 5, 0, "R8");
    cyc(0, 0, 0, "R2");
    // R7: divider 3
    session(0, 3, 2, 0);
    cyc(0, 0, 1, "R7"); cyc(0, 0, 1, "R7"); cyc(1, 2, 0, "R7");
    cyc(0, 0, 1, "R7"); cyc(1, 2, 0, "R7");
    // R6: k = 0 keeps slot 0
    session(0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(1, i * 5, 1, "R6");
    // R6 R7: k = 7 with divider 16 at top index
    session(0, 7, 15, 0);
    for (int i = 0; i < 40; i++) cyc(i % 3 == 0, 31, 1, "R6");

    // R9: enable drop mid-run, then restart from zero
    session(0, 3, 0, 0);
    for (int i = 0; i < 5; i++) cyc(1, 1, 1, "R5");
    enable_i = 1'b0;
    cyc(1, 7, 1, "R9");
    cyc(1, 7, 0, "R9");
    enable_i = 1'b1;
    cyc(1, 1, 0, "R9");

    // random sessions
    for (int s = 0; s < 24; s++) begin
      session(bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 15)), int'($urandom_range(0, 20)));
      for (int i = 0; i < 150; i++)
        cyc(bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)),
            $urandom_range(0, 2) == 0, ordered_mode_i ? "R3" : "R5");
    end

    done_run = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    while (!done_run) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        fails++;
        $display("FAIL watchdog: cycles=%0d, expected <= %0d", cycles, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end
endmodule